// File: doc/BRIEF.md
# Paired Gated Timer Bank with Clock-Source Selection

The block holds four 16-bit up-counting timers, numbered 1 to 4 and grouped as two pairs: timers 1 and 2 form pair A, and timers 3 and 4 form pair B. Each timer compares its count with a programmable reference value. When the count reaches that value the timer acts on its own output pin. It can drive a one-period low pulse or toggle the pin. After the match the counter either reloads to zero or keeps running until it wraps. Each pair has one external gate input. A timer that is enabled for gating stops counting while its pair's synchronized gate is high, and it restarts from zero when that gate falls. Either pair can be linked so that the lower timer's match event drives the upper timer's count input, which gives one 32-bit timer.

All timers advance on a shared count enable. That enable comes from one of three sources, chosen by a fixed precedence. The dedicated timer-clock pin wins when it is selected. Otherwise the external clock pin is used through the baud-rate path when that pin is enabled. If neither applies, an internal enable is active on every cycle. Both clock pins are synchronized, and a count step happens on each synchronized rising edge.

Configuration enters through a single write port with a valid/ready handshake. The ready line is held high at all times, so the block never applies back-pressure. A write is accepted on any clock edge where valid is high.

Top module: `quad_gated_timer`

## Requirements
- R1: After an asynchronous active-low reset, every timer output is high, every counter is zero and every configuration field is zero.
- R2: A running timer that is neither held nor restarted adds one on each count step. When it steps while its count equals the reference, that is a match. In restart mode (mode bit 1 = 1) the count becomes zero on the cycle after a match. In free-run mode it keeps adding and wraps from 0xFFFF to 0.
- R3: In pulse mode (mode bit 2 = 0) a match drives the timer output low, and the next count-enable step drives it high again unless that step is itself a match.
- R4: In toggle mode (mode bit 2 = 1) a match inverts the timer output, and the output changes at no other time.
- R5: Each gate input passes through two synchronizing flops. While the synchronized gate is high, a running timer with gate enable (mode bit 3 = 1) holds its count.
- R6: On a falling edge of the synchronized gate, a running timer with gate enable sets its count to zero on the next cycle.
- R7: Gate input bit 0 serves timers 1 and 2, and gate input bit 1 serves timers 3 and 4. A timer with gate enable cleared ignores its gate.
- R8: With the cascade bit of a pair set (global bit 2 for pair A, bit 3 for pair B), the upper timer steps only on the lower timer's match events. The upper timer matches only in a cycle where the lower one matches.
- R9: The count enable follows rising edges of the synchronized timer-clock pin when global bit 0 is set. Otherwise it follows rising edges of the synchronized external clock pin when global bit 1 is set. Otherwise it is active on every cycle.
- R10: The write address is {kind[1:0], timer index[1:0]}, where index 0 is timer 1. Kind 0 writes the mode bits (bit 0 run, bit 1 restart, bit 2 toggle, bit 3 gate enable), kind 1 writes the 16-bit reference, and kind 2 writes the global bits. cfg_ready is always 1, and a write affects counting from the next cycle on.
- R11: A timer with its run bit cleared keeps its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration write request |
| cfg_ready | output | 1 | Always high; the write is taken on the same edge |
| cfg_addr | input | 4 | Write address {kind, timer index} |
| cfg_data | input | 16 | Write data |
| tmr_clk_pin | input | 1 | Dedicated timer-clock pin |
| ext_clk_pin | input | 1 | External clock pin for the baud-rate path |
| gate_in | input | 2 | Per-pair gate inputs |
| tout | output | 4 | Timer outputs; bit 0 is timer 1 |

## Verification
The bench compares every output cycle against a cycle-level model. It targets the following corner cases:
- A reference of zero in restart mode, which matches on every step. A design that restores a pulse without checking for a new match would let the output rise when it should stay low.
- A gate that falls while held, which must clear the count. A design that only resumes would shift the output phase.
- A cascade whose lower timer matches while the upper timer sits at its own reference. A design that advances the upper timer on every step would fire it early.
- The clock precedence case, with both clock pins toggling at different rates. Choosing the wrong source changes the output period.
- A long free-run stretch, which exposes a wrong wrap point.

// File: rtl/qtm_pkg.sv
package qtm_pkg;
  localparam logic [1:0] KIND_MODE = 2'd0;
  localparam logic [1:0] KIND_REF  = 2'd1;
  localparam logic [1:0] KIND_GLOB = 2'd2;

  typedef struct packed {
    logic gate_en;
    logic toggle;
    logic restart;
    logic run;
  } tmode_t;
endpackage

// File: rtl/qtm_cfg_regs.sv
module qtm_cfg_regs
  import qtm_pkg::*;
#(
  parameter int N_TMR   = 4,
  parameter int N_PAIRS = 2,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_valid,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [CNT_W-1:0]                wr_data,
  output tmode_t [N_TMR-1:0]              mode,
  output logic   [N_TMR-1:0][CNT_W-1:0]   refv,
  output logic                            tm_sel,
  output logic                            ext_en,
  output logic   [N_PAIRS-1:0]            casc
);
  localparam int IDX_W = ADDR_W - 2;

  logic [1:0]       kind;
  logic [IDX_W-1:0] idx;
  assign kind = wr_addr[ADDR_W-1 -: 2];
  assign idx  = wr_addr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= '0;
      refv   <= '0;
      tm_sel <= 1'b0;
      ext_en <= 1'b0;
      casc   <= '0;
    end else if (wr_valid) begin
      case (kind)
        KIND_MODE: if (int'(idx) < N_TMR) mode[idx] <= tmode_t'(wr_data[3:0]);
        KIND_REF:  if (int'(idx) < N_TMR) refv[idx] <= wr_data;
        KIND_GLOB: begin
          tm_sel <= wr_data[0];
          ext_en <= wr_data[1];
          casc   <= wr_data[2 +: N_PAIRS];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qtm_clk_sel.sv
module qtm_clk_sel #(
  parameter int SYNC_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tm_pin,
  input  logic ext_pin,
  input  logic tm_sel,
  input  logic ext_en,
  output logic tick
);
  logic [SYNC_W-1:0] tm_sh, ext_sh;
  logic tm_rise, ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_sh  <= '0;
      ext_sh <= '0;
    end else begin
      tm_sh  <= {tm_sh[SYNC_W-2:0], tm_pin};
      ext_sh <= {ext_sh[SYNC_W-2:0], ext_pin};
    end
  end

  assign tm_rise  = tm_sh[SYNC_W-2]  & ~tm_sh[SYNC_W-1];
  assign ext_rise = ext_sh[SYNC_W-2] & ~ext_sh[SYNC_W-1];

  always_comb begin
    if (tm_sel)      tick = tm_rise;
    else if (ext_en) tick = ext_rise;
    else             tick = 1'b1;
  end

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  AST_TMCLK_PRECEDES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && tm_sel && tick) |-> ($past(tm_pin, 2) && !$past(tm_pin, 3))); // R9
  AST_EXT_WHEN_NO_TM: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && !tm_sel && ext_en && tick) |-> ($past(ext_pin, 2) && !$past(ext_pin, 3))); // R9
endmodule

// File: rtl/qtm_gate_sync.sv
module qtm_gate_sync #(
  parameter int N_PAIRS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PAIRS-1:0] gate_raw,
  output logic [N_PAIRS-1:0] gate_hi,
  output logic [N_PAIRS-1:0] gate_fall
);
  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], gate_raw[p]};
    end
    assign gate_hi[p]   = sh[1];
    assign gate_fall[p] = sh[2] & ~sh[1];
  end
endmodule

// File: rtl/qtm_timer_core.sv
module qtm_timer_core
  import qtm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmode_t           mode,
  input  logic [CNT_W-1:0] ref_v,
  input  logic             tick,
  input  logic             adv,
  input  logic             gate_hi,
  input  logic             gate_fall,
  output logic             ev,
  output logic             tout
);
  logic [CNT_W-1:0] cnt_q;
  logic restart_g, hold_g, go;

  assign restart_g = mode.run && mode.gate_en && gate_fall;
  assign hold_g    = mode.gate_en && gate_hi;
  assign go        = mode.run && !restart_g && !hold_g && adv;
  assign ev        = go && (cnt_q == ref_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_g) cnt_q <= '0;
    else if (go)        cnt_q <= (ev && mode.restart) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              tout <= 1'b1;
    else if (ev)                             tout <= mode.toggle ? ~tout : 1'b0;
    else if (!mode.toggle && !tout && tick)  tout <= 1'b1;
  end

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.run && mode.gate_en && gate_hi && !gate_fall) |=> $stable(cnt_q)); // R5
  AST_GATE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.run && mode.gate_en && gate_fall) |=> (cnt_q == '0)); // R6
  AST_REF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && mode.restart) |=> (cnt_q == '0)); // R2
  AST_LOW_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tout) |-> $past(ev)); // R3
  AST_TOGGLE_ONLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((tout != $past(tout)) && !$past(ev)) |-> ($past(!mode.toggle) && $past(tick))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.run |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/quad_gated_timer.sv
module quad_gated_timer
  import qtm_pkg::*;
#(
  parameter int N_PAIRS = 2,
  parameter int CNT_W   = 16,
  localparam int N_TMR  = 2 * N_PAIRS,
  localparam int ADDR_W = 2 + $clog2(N_TMR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [CNT_W-1:0]   cfg_data,
  input  logic               tmr_clk_pin,
  input  logic               ext_clk_pin,
  input  logic [N_PAIRS-1:0] gate_in,
  output logic [N_TMR-1:0]   tout
);
  tmode_t [N_TMR-1:0]            mode;
  logic   [N_TMR-1:0][CNT_W-1:0] refv;
  logic                          tm_sel, ext_en, tick;
  logic   [N_PAIRS-1:0]          casc, gate_hi, gate_fall;
  logic   [N_TMR-1:0]            ev, adv;

  assign cfg_ready = 1'b1;

  qtm_cfg_regs #(.N_TMR(N_TMR), .N_PAIRS(N_PAIRS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_valid(cfg_valid), .wr_addr(cfg_addr), .wr_data(cfg_data),
    .mode(mode), .refv(refv), .tm_sel(tm_sel), .ext_en(ext_en), .casc(casc));

  qtm_clk_sel #(.SYNC_W(3)) u_clk (
    .clk(clk), .rst_n(rst_n), .tm_pin(tmr_clk_pin), .ext_pin(ext_clk_pin),
    .tm_sel(tm_sel), .ext_en(ext_en), .tick(tick));

  qtm_gate_sync #(.N_PAIRS(N_PAIRS)) u_gate (
    .clk(clk), .rst_n(rst_n), .gate_raw(gate_in), .gate_hi(gate_hi), .gate_fall(gate_fall));

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    if (t % 2 == 1) begin : g_upper
      assign adv[t] = casc[t/2] ? ev[t-1] : tick;
    end else begin : g_lower
      assign adv[t] = tick;
    end
    qtm_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .mode(mode[t]), .ref_v(refv[t]), .tick(tick),
      .adv(adv[t]), .gate_hi(gate_hi[t/2]), .gate_fall(gate_fall[t/2]),
      .ev(ev[t]), .tout(tout[t]));
  end

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_casc_chk
    AST_CASC_UPPER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (casc[p] && ev[2*p+1]) |-> ev[2*p]); // R8
  end
endmodule

// File: tb/quad_gated_timer_tb_top.sv
module quad_gated_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_data = '0;
  logic        tmr_clk_pin = 1'b0;
  logic        ext_clk_pin = 1'b0;
  logic [1:0]  gate_in = '0;
  logic [3:0]  tout;

  always #5 clk = ~clk;

  quad_gated_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .tmr_clk_pin(tmr_clk_pin),
    .ext_clk_pin(ext_clk_pin), .gate_in(gate_in), .tout(tout));

  int    n_chk = 0;
  int    n_bad = 0;
  bit    chk_on = 1'b0;
  string cur_req = "R1";

  // model state, built from the requirements
  logic [15:0] m_cnt [4];
  logic [15:0] m_ref [4];
  logic [3:0]  m_mode [4];
  logic [3:0]  m_tout;
  logic [3:0]  m_ev;
  logic        m_tms, m_ext;
  logic [1:0]  m_casc;
  logic [2:0]  m_tsh, m_esh;
  logic [2:0]  m_gsh [2];

  function automatic logic sel_tick(logic tms, logic ext, logic [2:0] tsh, logic [2:0] esh);
    if (tms) return tsh[1] & ~tsh[2];   // R9 precedence
    if (ext) return esh[1] & ~esh[2];
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_cnt[i] = '0; m_ref[i] = '0; m_mode[i] = '0;
      end
      m_tout = 4'hF; m_ev = '0; m_tms = 0; m_ext = 0; m_casc = '0;
      m_tsh = '0; m_esh = '0; m_gsh[0] = '0; m_gsh[1] = '0;
    end else begin
      logic tk;
      tk = sel_tick(m_tms, m_ext, m_tsh, m_esh);
      for (int i = 0; i < 4; i++) begin
        logic run, rs, tg, ge, hi, fl, adv;
        run = m_mode[i][0]; rs = m_mode[i][1]; tg = m_mode[i][2]; ge = m_mode[i][3];
        hi  = m_gsh[i/2][1];
        fl  = m_gsh[i/2][2] & ~m_gsh[i/2][1];
        adv = ((i % 2 == 1) && m_casc[i/2]) ? m_ev[i-1] : tk;
        m_ev[i] = 1'b0;
        if (run) begin
          if (ge && fl) m_cnt[i] = '0;
          else if (!(ge && hi) && adv) begin
            m_ev[i] = (m_cnt[i] == m_ref[i]);
            m_cnt[i] = (m_ev[i] && rs) ? 16'd0 : m_cnt[i] + 16'd1;
          end
        end
        if (m_ev[i]) m_tout[i] = tg ? ~m_tout[i] : 1'b0;
        else if (!tg && !m_tout[i] && tk) m_tout[i] = 1'b1;
      end
      m_tsh = {m_tsh[1:0], tmr_clk_pin};
      m_esh = {m_esh[1:0], ext_clk_pin};
      m_gsh[0] = {m_gsh[0][1:0], gate_in[0]};
      m_gsh[1] = {m_gsh[1][1:0], gate_in[1]};
      if (cfg_valid) begin
        case (cfg_addr[3:2])
          2'd0: m_mode[cfg_addr[1:0]] = cfg_data[3:0];
          2'd1: m_ref[cfg_addr[1:0]]  = cfg_data;
          2'd2: begin m_tms = cfg_data[0]; m_ext = cfg_data[1]; m_casc = cfg_data[3:2]; end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      n_chk++;
      if (tout !== m_tout) begin
        n_bad++;
        $display("FAIL %s tout actual=%b expected=%b at %0t", cur_req, tout, m_tout, $time);
      end
    end
  end

  task automatic wr(input logic [1:0] kind, input logic [1:0] idx, input logic [15:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_addr = {kind, idx}; cfg_data = d;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic run_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic all_off();
    for (int i = 0; i < 4; i++) wr(2'd0, i[1:0], 16'd0);
    wr(2'd2, 2'd0, 16'd0);
  endtask

  task automatic finish_run();
    chk_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd20250607));
    run_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    n_chk++;
    if (tout !== 4'hF) begin
      n_bad++; $display("FAIL R1 tout actual=%b expected=1111", tout);
    end
    // R10: ready is always high
    n_chk++;
    if (cfg_ready !== 1'b1) begin
      n_bad++; $display("FAIL R10 cfg_ready actual=%b expected=1", cfg_ready);
    end
    chk_on = 1'b1;

    // R2 / R4: restart mode, toggle, reference 3, internal enable
    cur_req = "R2";
    wr(2'd1, 2'd0, 16'd3);
    wr(2'd0, 2'd0, 16'b0111);
    run_cycles(40);
    cur_req = "R4";
    wr(2'd1, 2'd1, 16'd0);            // ref 0 toggles every step
    wr(2'd0, 2'd1, 16'b0111);
    run_cycles(20);

    // R3: pulse mode, including ref 0 which holds low
    cur_req = "R3";
    all_off();
    wr(2'd1, 2'd2, 16'd2);
    wr(2'd0, 2'd2, 16'b0011);
    wr(2'd0, 2'd3, 16'b0011);
    wr(2'd1, 2'd3, 16'd0);
    run_cycles(30);

    // R5 / R6 / R7: gate on pair B, timer 3 gated, timer 4 not
    cur_req = "R5";
    all_off();
    wr(2'd1, 2'd2, 16'd5);
    wr(2'd1, 2'd3, 16'd5);
    wr(2'd0, 2'd2, 16'b1111);
    wr(2'd0, 2'd3, 16'b0111);
    run_cycles(9);
    gate_in = 2'b10; run_cycles(15);
    cur_req = "R6";
    gate_in = 2'b00; run_cycles(20);
    cur_req = "R7";
    gate_in = 2'b01; run_cycles(20);   // pair A gate must not touch pair B
    gate_in = 2'b00;

    // R8: cascade pair A
    cur_req = "R8";
    all_off();
    wr(2'd1, 2'd0, 16'd1);
    wr(2'd1, 2'd1, 16'd2);
    wr(2'd0, 2'd0, 16'b0111);
    wr(2'd0, 2'd1, 16'b0111);
    wr(2'd2, 2'd0, 16'b0100);
    run_cycles(60);

    // R9: clock source precedence
    cur_req = "R9";
    wr(2'd2, 2'd0, 16'b0111);          // timer pin wins over ext
    for (int k = 0; k < 80; k++) begin
      ext_clk_pin = ~ext_clk_pin;
      if (k % 4 == 0) tmr_clk_pin = ~tmr_clk_pin;
      @(negedge clk);
    end
    wr(2'd2, 2'd0, 16'b0110);          // ext path
    for (int k = 0; k < 80; k++) begin
      ext_clk_pin = ~ext_clk_pin;
      tmr_clk_pin = ~tmr_clk_pin;
      @(negedge clk);
    end
    wr(2'd2, 2'd0, 16'b0100);          // internal
    run_cycles(20);

    // R11: stopped timers hold
    cur_req = "R11";
    wr(2'd0, 2'd0, 16'b0110);
    run_cycles(20);
    wr(2'd0, 2'd0, 16'b0111);
    run_cycles(20);

    // R10: random configurations across all modes
    cur_req = "R10";
    for (int r = 0; r < 30; r++) begin
      for (int i = 0; i < 4; i++) begin
        wr(2'd1, i[1:0], 16'($urandom_range(0, 7)));
        wr(2'd0, i[1:0], 16'($urandom_range(0, 15)));
      end
      wr(2'd2, 2'd0, 16'($urandom_range(0, 15)));
      for (int k = 0; k < 200; k++) begin
        if ($urandom_range(0, 9) == 0) gate_in = 2'($urandom);
        tmr_clk_pin = 1'($urandom);
        ext_clk_pin = 1'($urandom);
        @(negedge clk);
      end
    end
    gate_in = '0;

    // R2: free-run wrap with reference 5
    cur_req = "R2";
    all_off();
    wr(2'd1, 2'd0, 16'd5);
    wr(2'd0, 2'd0, 16'b0101);
    run_cycles(66000);

    finish_run();
  end
endmodule